// File: doc/BRIEF.md
# Dual-Path Ping-Pong Clock Root Slice

This block is a clock root slice that picks one of eight source clocks, gates it, divides it and hands the result on as a clock-enable pulse. Inside the slice there are two selector paths, A and B. Each path has its own source select, its own gate and its own pre-divider. A single write port shows software one plain chain of select, gate, pre-divide and post-divide, and hides the two paths. On each accepted write the block loads the new settings into the idle path and then flips an internal toggle. The toggle moves the output mux onto that path, so the path that is driving the output is never disturbed.

A path can only be reprogrammed while the source it is currently fed from is running. If the idle path still sits on a source that has since been switched off, the write stalls. It stays pending and raises a sticky busy flag until that source comes back. Writing the same source twice in a row loads it into both paths. After that, the old source may be switched off without blocking the next change. All clocks are modelled as tick enables on one reference clock, together with an active bit per source. The slice can be built with the pre-divider (bus type) or without it (core type).

Top module: `clk_root_slice`

## Requirements
- R1: After reset, both selectors hold source 0 and path A drives the output (`path_o`=0). `busy_o` is low, both path gates are open and both dividers divide by 1, so a source ticking every cycle gives `clk_en_o` high every cycle.
- R2: A write accepted while not busy loads source, gate and pre-divide into the idle path when the idle path's current source is active. In the next cycle `path_o` points at that path, and the selector of the previously driving path is unchanged.
- R3: `path_o` is 0 when path A drives the output and 1 when path B drives it. Output pulses come only from the driving path.
- R4: If the idle path's current source has its active bit low when a write is accepted, `busy_o` rises the next cycle. Neither selector changes and `path_o` keeps its value for as long as that source stays inactive.
- R5: On the first clock edge where the stalled path's current source is active again, the pending write commits. In the next cycle `busy_o` is low, the selector holds the pending source and `path_o` has flipped.
- R6: While `busy_o` is high, further writes are ignored entirely, including their post-divide field. The commit uses the settings of the stalled write.
- R7: Two writes of the same source leave both selectors on it. A later deactivation of the earlier source does not stall the next write.
- R8: A write with `wr_gate_i`=0 stores a closed gate with its path. Once that path drives the output, `clk_en_o` stays low.
- R9: With `HAS_PREDIV`=1 the pre-divider divides the path's ticks by `wr_pre_i`+1 (1..8). With `HAS_PREDIV`=0 that field is ignored and the division is 1.
- R10: The post-divider divides the driving path's pulses by `wr_post_i`+1 (1..64). `clk_en_o` is registered and comes one cycle after the qualifying tick. An accepted write loads the post-divide value at once and restarts its count.
- R11: A source tick counts only while that source's active bit is high. A driving path on an inactive source produces no `clk_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | NUM_SRC | Per-source tick enable |
| src_active_i | input | NUM_SRC | Per-source liveness |
| wr_i | input | 1 | Write strobe of the target register |
| wr_src_i | input | $clog2(NUM_SRC) | Requested source index |
| wr_gate_i | input | 1 | Gate open (1) or closed (0) |
| wr_pre_i | input | PRE_W | Pre-divide minus one |
| wr_post_i | input | POST_W | Post-divide minus one |
| busy_o | output | 1 | Stalled switch pending |
| path_o | output | 1 | Driving path, 0=A, 1=B |
| sel_a_o | output | $clog2(NUM_SRC) | Source held by path A |
| sel_b_o | output | $clog2(NUM_SRC) | Source held by path B |
| clk_en_o | output | 1 | Divided clock-enable pulse |

## Verification
The bench builds two instances with eight sources, a 3-bit pre field and a 6-bit post field. One has `HAS_PREDIV`=1 and the other has `HAS_PREDIV`=0, so the same write sequence runs through both generate branches. Comparing their output rates shows that the core variant ignores the pre field. Because every source ticks at its own rate, the stall-on-dead-source sequence, the release and the repeated-write recovery can all be replayed, and each step can be checked against a behavioural model.

// File: rtl/clk_slice_pkg.sv
package clk_slice_pkg;
  typedef enum logic {
    PATH_A = 1'b0,
    PATH_B = 1'b1
  } path_e;
endpackage

// File: rtl/clk_slice_ctrl.sv
module clk_slice_ctrl
  import clk_slice_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRE_W   = 3,
  parameter int POST_W  = 6,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SRC-1:0]         src_active_i,
  input  logic                       wr_i,
  input  logic [SEL_W-1:0]           wr_src_i,
  input  logic                       wr_gate_i,
  input  logic [PRE_W-1:0]           wr_pre_i,
  input  logic [POST_W-1:0]          wr_post_i,
  output logic [1:0][SEL_W-1:0]      sel_o,
  output logic [1:0]                 gate_o,
  output logic [1:0][PRE_W-1:0]      pre_o,
  output logic [1:0]                 clr_path_o,
  output logic [POST_W-1:0]          post_o,
  output logic                       post_clr_o,
  output logic                       path_o,
  output logic                       busy_o
);
  path_e                  path_q, idle;
  logic [1:0][SEL_W-1:0]  sel_q;
  logic [1:0]             gate_q;
  logic [1:0][PRE_W-1:0]  pre_q;
  logic                   busy_q;
  logic [SEL_W-1:0]       pend_src;
  logic                   pend_gate;
  logic [PRE_W-1:0]       pend_pre;
  logic [POST_W-1:0]      post_q;
  logic                   idle_ok, accept, commit;
  logic [SEL_W-1:0]       new_src;
  logic                   new_gate;
  logic [PRE_W-1:0]       new_pre;

  always_comb idle = (path_q == PATH_A) ? PATH_B : PATH_A;

  // the idle selector can only move while its present source runs
  assign idle_ok  = src_active_i[sel_q[idle]];
  assign accept   = wr_i & ~busy_q;
  assign commit   = (busy_q | accept) & idle_ok;
  assign new_src  = busy_q ? pend_src  : wr_src_i;
  assign new_gate = busy_q ? pend_gate : wr_gate_i;
  assign new_pre  = busy_q ? pend_pre  : wr_pre_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      path_q    <= PATH_A;
      sel_q     <= '0;
      gate_q    <= '1;
      pre_q     <= '0;
      busy_q    <= 1'b0;
      pend_src  <= '0;
      pend_gate <= 1'b0;
      pend_pre  <= '0;
      post_q    <= '0;
    end else begin
      if (commit) begin
        sel_q[idle]  <= new_src;
        gate_q[idle] <= new_gate;
        pre_q[idle]  <= new_pre;
        path_q       <= idle;
      end
      if (busy_q && idle_ok) begin
        busy_q <= 1'b0;
      end else if (accept && !idle_ok) begin
        busy_q    <= 1'b1;
        pend_src  <= wr_src_i;
        pend_gate <= wr_gate_i;
        pend_pre  <= wr_pre_i;
      end
      if (accept) post_q <= wr_post_i;
    end
  end

  always_comb begin
    clr_path_o = '0;
    if (commit) clr_path_o[idle] = 1'b1;
  end

  assign sel_o      = sel_q;
  assign gate_o     = gate_q;
  assign pre_o      = pre_q;
  assign post_o     = post_q;
  assign post_clr_o = accept;
  assign path_o     = path_q;
  assign busy_o     = busy_q;
endmodule

// File: rtl/clk_slice_path.sv
module clk_slice_path #(
  parameter int NUM_SRC    = 8,
  parameter int PRE_W      = 3,
  parameter bit HAS_PREDIV = 1'b1,
  localparam int SEL_W     = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [NUM_SRC-1:0] src_active_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               gate_i,
  input  logic [PRE_W-1:0]   pre_i,
  input  logic               clr_i,
  output logic               pulse_o
);
  logic tick;

  assign tick = gate_i & src_tick_i[sel_i] & src_active_i[sel_i];

  if (HAS_PREDIV) begin : g_prediv
    logic [PRE_W-1:0] cnt_q;
    logic             wrap;

    assign wrap    = (cnt_q == pre_i);
    assign pulse_o = tick & wrap;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (tick)   cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end else begin : g_bypass
    logic unused_pre;
    assign unused_pre = ^{pre_i, clr_i, clk_i, rst_ni};
    assign pulse_o    = tick;
  end
endmodule

// File: rtl/clk_slice_postdiv.sv
module clk_slice_postdiv #(
  parameter int POST_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic [POST_W-1:0] div_i,
  input  logic              clr_i,
  output logic              en_o
);
  logic [POST_W-1:0] cnt_q;
  logic              wrap;

  assign wrap = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_o  <= 1'b0;
    end else begin
      en_o <= pulse_i & wrap;
      if (clr_i)        cnt_q <= '0;
      else if (pulse_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clk_root_slice.sv
module clk_root_slice #(
  parameter int NUM_SRC    = 8,
  parameter int PRE_W      = 3,
  parameter int POST_W     = 6,
  parameter bit HAS_PREDIV = 1'b1,
  localparam int SEL_W     = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [NUM_SRC-1:0] src_active_i,
  input  logic               wr_i,
  input  logic [SEL_W-1:0]   wr_src_i,
  input  logic               wr_gate_i,
  input  logic [PRE_W-1:0]   wr_pre_i,
  input  logic [POST_W-1:0]  wr_post_i,
  output logic               busy_o,
  output logic               path_o,
  output logic [SEL_W-1:0]   sel_a_o,
  output logic [SEL_W-1:0]   sel_b_o,
  output logic               clk_en_o
);
  logic [1:0][SEL_W-1:0] sel;
  logic [1:0]            gate;
  logic [1:0][PRE_W-1:0] pre;
  logic [1:0]            clr_path;
  logic [1:0]            pulse;
  logic [POST_W-1:0]     post;
  logic                  post_clr;
  logic                  mux_pulse;

  clk_slice_ctrl #(
    .NUM_SRC(NUM_SRC), .PRE_W(PRE_W), .POST_W(POST_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_active_i(src_active_i),
    .wr_i        (wr_i),
    .wr_src_i    (wr_src_i),
    .wr_gate_i   (wr_gate_i),
    .wr_pre_i    (wr_pre_i),
    .wr_post_i   (wr_post_i),
    .sel_o       (sel),
    .gate_o      (gate),
    .pre_o       (pre),
    .clr_path_o  (clr_path),
    .post_o      (post),
    .post_clr_o  (post_clr),
    .path_o      (path_o),
    .busy_o      (busy_o)
  );

  for (genvar p = 0; p < 2; p++) begin : g_path
    clk_slice_path #(
      .NUM_SRC(NUM_SRC), .PRE_W(PRE_W), .HAS_PREDIV(HAS_PREDIV)
    ) u_path (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .src_tick_i  (src_tick_i),
      .src_active_i(src_active_i),
      .sel_i       (sel[p]),
      .gate_i      (gate[p]),
      .pre_i       (pre[p]),
      .clr_i       (clr_path[p]),
      .pulse_o     (pulse[p])
    );
  end

  assign mux_pulse = path_o ? pulse[1] : pulse[0];

  clk_slice_postdiv #(.POST_W(POST_W)) u_post (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(mux_pulse),
    .div_i  (post),
    .clr_i  (post_clr),
    .en_o   (clk_en_o)
  );

  assign sel_a_o = sel[0];
  assign sel_b_o = sel[1];
endmodule

// File: rtl/clk_root_slice_chk.sv
module clk_root_slice_chk #(
  parameter int NUM_SRC = 8,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_tick_i,
  input logic [NUM_SRC-1:0] src_active_i,
  input logic               wr_i,
  input logic               busy_o,
  input logic               path_o,
  input logic [SEL_W-1:0]   sel_a_o,
  input logic [SEL_W-1:0]   sel_b_o,
  input logic               clk_en_o
);
  logic idle_live;
  assign idle_live = src_active_i[path_o ? sel_a_o : sel_b_o];

  a_r4_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !idle_live) |=> busy_o);

  a_r4_busy_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_i));

  a_r2_drive_a_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !path_o |=> $stable(sel_a_o));

  a_r2_drive_b_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path_o |=> $stable(sel_b_o));

  a_r2_path_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !busy_o) |=> $stable(path_o));

  a_r11_en_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> $past(|(src_tick_i & src_active_i)));
endmodule

bind clk_root_slice clk_root_slice_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_tick_i  (src_tick_i),
  .src_active_i(src_active_i),
  .wr_i        (wr_i),
  .busy_o      (busy_o),
  .path_o      (path_o),
  .sel_a_o     (sel_a_o),
  .sel_b_o     (sel_b_o),
  .clk_en_o    (clk_en_o)
);

// File: tb/clk_root_slice_tb.sv
`timescale 1ns/1ps

module clk_root_slice_model #(
  parameter bit HAS_PRE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tick,
  input  logic [7:0] act,
  input  logic       wr,
  input  logic [2:0] wsrc,
  input  logic       wgate,
  input  logic [2:0] wpre,
  input  logic [5:0] wpost,
  output int         e_sel_a,
  output int         e_sel_b,
  output int         e_path,
  output int         e_busy,
  output int         e_en
);
  int sel[2], gate[2], pre[2], pc[2];
  int tog, busy, ps, pg, pp, post, qc, en, idle, m;
  bit pl[2];
  bit t;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin sel[p] = 0; gate[p] = 1; pre[p] = 0; pc[p] = 0; end
      tog = 0; busy = 0; ps = 0; pg = 0; pp = 0; post = 0; qc = 0; en = 0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        t = tick[sel[p]] && act[sel[p]] && (gate[p] != 0);
        if (HAS_PRE) begin
          pl[p] = t && (pc[p] == pre[p]);
          if (t) pc[p] = (pc[p] == pre[p]) ? 0 : pc[p] + 1;
        end else pl[p] = t;
      end
      m  = pl[tog] ? 1 : 0;
      en = (m != 0 && qc == post) ? 1 : 0;
      if (m != 0) qc = (qc == post) ? 0 : qc + 1;
      idle = 1 - tog;
      if (busy != 0) begin
        if (act[sel[idle]]) begin
          sel[idle] = ps; gate[idle] = pg; pre[idle] = pp; pc[idle] = 0;
          tog = idle; busy = 0;
        end
      end else if (wr) begin
        post = wpost; qc = 0;
        if (act[sel[idle]]) begin
          sel[idle] = wsrc; gate[idle] = wgate; pre[idle] = wpre; pc[idle] = 0;
          tog = idle;
        end else begin
          busy = 1; ps = wsrc; pg = wgate; pp = wpre;
        end
      end
    end
    e_sel_a = sel[0]; e_sel_b = sel[1]; e_path = tog; e_busy = busy; e_en = en;
  end
endmodule

module clk_root_slice_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tick = '0;
  logic [7:0] act = 8'hFF;
  logic       wr = 1'b0;
  logic [2:0] wsrc = '0;
  logic       wgate = 1'b1;
  logic [2:0] wpre = '0;
  logic [5:0] wpost = '0;
  int total = 0, bad = 0, cyc = 0;

  logic       b_busy, b_path, b_en, c_busy, c_path, c_en;
  logic [2:0] b_sa, b_sb, c_sa, c_sb;
  int mb_sa, mb_sb, mb_path, mb_busy, mb_en;
  int mc_sa, mc_sb, mc_path, mc_busy, mc_en;

  always #2.5 clk = ~clk;

  clk_root_slice #(.NUM_SRC(8), .PRE_W(3), .POST_W(6), .HAS_PREDIV(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(tick), .src_active_i(act),
    .wr_i(wr), .wr_src_i(wsrc), .wr_gate_i(wgate), .wr_pre_i(wpre), .wr_post_i(wpost),
    .busy_o(b_busy), .path_o(b_path), .sel_a_o(b_sa), .sel_b_o(b_sb), .clk_en_o(b_en));

  clk_root_slice #(.NUM_SRC(8), .PRE_W(3), .POST_W(6), .HAS_PREDIV(1'b0)) u_core (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(tick), .src_active_i(act),
    .wr_i(wr), .wr_src_i(wsrc), .wr_gate_i(wgate), .wr_pre_i(wpre), .wr_post_i(wpost),
    .busy_o(c_busy), .path_o(c_path), .sel_a_o(c_sa), .sel_b_o(c_sb), .clk_en_o(c_en));

  clk_root_slice_model #(.HAS_PRE(1'b1)) u_mb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .act(act), .wr(wr), .wsrc(wsrc),
    .wgate(wgate), .wpre(wpre), .wpost(wpost), .e_sel_a(mb_sa), .e_sel_b(mb_sb),
    .e_path(mb_path), .e_busy(mb_busy), .e_en(mb_en));

  clk_root_slice_model #(.HAS_PRE(1'b0)) u_mc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .act(act), .wr(wr), .wsrc(wsrc),
    .wgate(wgate), .wpre(wpre), .wpost(wpost), .e_sel_a(mc_sa), .e_sel_b(mc_sb),
    .e_path(mc_path), .e_busy(mc_busy), .e_en(mc_en));

  task automatic chk(string tag, int actual, int expect_v);
    total++;
    if (actual != expect_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, actual, expect_v, $time);
    end
  endtask

  // source i ticks every i+1 cycles
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < 8; i++) tick[i] <= ((cyc % (i + 1)) == 0);
  end

  // per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 bus busy",  int'(b_busy), mb_busy);
      chk("R3 bus path",  int'(b_path), mb_path);
      chk("R2 bus sel_a", int'(b_sa),   mb_sa);
      chk("R2 bus sel_b", int'(b_sb),   mb_sb);
      chk("R10 bus en",   int'(b_en),   mb_en);
      chk("R4 core busy", int'(c_busy), mc_busy);
      chk("R3 core path", int'(c_path), mc_path);
      chk("R2 core sel_a", int'(c_sa),  mc_sa);
      chk("R2 core sel_b", int'(c_sb),  mc_sb);
      chk("R9 core en",   int'(c_en),   mc_en);
    end
  end

  task automatic write(int s, int g, int p, int q);
    @(negedge clk);
    wr = 1'b1; wsrc = 3'(s); wgate = g[0]; wpre = 3'(p); wpost = 6'(q);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic count_en(int n, output int nb, output int nc);
    nb = 0; nc = 0;
    repeat (n) begin
      @(negedge clk);
      nb += int'(b_en); nc += int'(c_en);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nb, nc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sel_a", int'(b_sa), 0);
    chk("R1 sel_b", int'(b_sb), 0);
    chk("R1 path", int'(b_path), 0);
    chk("R1 busy", int'(b_busy), 0);
    count_en(5, nb, nc);
    chk("R1 bus div1", nb, 5);
    chk("R1 core div1", nc, 5);

    // hang scenario
    write(1, 1, 0, 0);
    chk("R2 sel_b loaded", int'(b_sb), 1);
    chk("R2 sel_a kept", int'(b_sa), 0);
    chk("R3 path to B", int'(b_path), 1);
    act[0] = 1'b0;
    write(2, 1, 0, 0);
    chk("R4 stall busy", int'(b_busy), 1);
    chk("R4 stall path", int'(b_path), 1);
    chk("R4 stall sel_a", int'(b_sa), 0);
    write(3, 1, 0, 9);
    repeat (3) @(negedge clk);
    chk("R4 stall persists", int'(b_busy), 1);
    act[0] = 1'b1;
    @(negedge clk);
    chk("R5 busy cleared", int'(b_busy), 0);
    chk("R6 pending kept not ignored write", int'(b_sa), 2);
    chk("R5 path flipped", int'(b_path), 0);
    chk("R5 core sel_a", int'(c_sa), 2);

    // double write recovery
    write(1, 1, 0, 0);
    write(1, 1, 0, 0);
    chk("R7 sel_a", int'(b_sa), 1);
    chk("R7 sel_b", int'(b_sb), 1);
    act[0] = 1'b0;
    write(2, 1, 0, 0);
    chk("R7 no stall", int'(b_busy), 0);
    chk("R7 sel_b new", int'(b_sb), 2);
    chk("R7 path", int'(b_path), 1);
    act = 8'hFF;

    // R8 gate closed
    write(0, 0, 0, 0);
    count_en(12, nb, nc);
    chk("R8 gate bus", nb, 0);
    chk("R8 gate core", nc, 0);

    // R9 pre-divide by 4
    write(0, 1, 3, 0);
    repeat (8) @(negedge clk);
    count_en(40, nb, nc);
    chk("R9 bus pre4", nb, 10);
    chk("R9 core ignores pre", nc, 40);

    // R10 post-divide by 5
    write(0, 1, 0, 4);
    repeat (8) @(negedge clk);
    count_en(50, nb, nc);
    chk("R10 bus post5", nb, 10);
    chk("R10 core post5", nc, 10);

    // R9 R10 combined 2 x 3
    write(0, 1, 1, 2);
    repeat (8) @(negedge clk);
    count_en(60, nb, nc);
    chk("R9 bus pre2 post3", nb, 10);
    chk("R10 core post3", nc, 20);

    // R11 inactive source gives no output
    write(0, 1, 0, 0);
    act[0] = 1'b0;
    @(negedge clk);
    count_en(20, nb, nc);
    chk("R11 bus idle src", nb, 0);
    chk("R11 core idle src", nc, 0);
    act = 8'hFF;
    repeat (4) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule